// File: doc/BRIEF.md
# Variable Element-Width Lane Adder

This block is the partitioned add unit of a vector-capable integer core. It splits a native 64-bit word into lanes and adds them lane by lane. Each operand carries its own 2-bit width code, and so does the destination. The code picks 8 bits, half the native width, the native width or twice the native width. With the default 64-bit native width the lane sizes are 8, 32, 64 and 128 bits. Each lane wraps on overflow, and no carry ever crosses a lane boundary.

Every source element is widened to the destination lane width before the add. The `is_signed` input picks sign or zero extension. The lane count comes from the widest of the destination and the sources involved. Source element `i` is read from packed position `i` at that source's own width. In add-immediate mode a 12-bit immediate replaces the second source. It is first sign-extended, then cut to the first source's element width. It is then extended in the same way as the sources and copied into every lane.

Operations enter and leave on valid/ready handshakes, with one output register between them. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that `out_ready` does not take stays unchanged on `result` for as long as it is stalled.

Top module: `vlane_adder`

## Requirements
- R1: Width code 0 selects 8-bit lanes, 1 selects 32-bit, 2 selects 64-bit and 3 selects 128-bit. Result lane `i` sits at bits `[i*W +: W]` of `result`. Bits above the last active lane read zero, so bits 127:64 are zero unless the destination code is 3.
- R2: Each lane sum wraps modulo 2^W, and a carry out of one lane never reaches the next lane.
- R3: With `is_signed` = 1 each source element is sign-extended. With `is_signed` = 0 it is zero-extended.
- R4: Sources narrower than the destination are widened to the destination width before the add. For example, 8-bit 0xFF plus 0x01 gives 0x100 in a 32-bit unsigned lane.
- R5: The lane count is 64 divided by the largest of the destination width, the first source width and (in register mode) the second source width, with every width capped at 64. Source element `i` comes from bits `[i*S +: S]` of its word, where S is that source's capped width. A source wider than the destination is truncated to the lane.
- R6: When `use_imm` = 1, the 12-bit `imm` is sign-extended and cut to the first source's element width. It is then extended as in R3 and added in every lane.
- R7: Destination code 3 forms a single 128-bit lane that spans the whole `result`, built from 64-bit (or narrower) source elements.
- R8: An accepted input appears with `out_valid` high on the next clock. While `out_valid` is high and `out_ready` is low, `result` and `out_valid` hold and `in_ready` is low. A drained register with no new input drops `out_valid`.
- R9: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0.
- R10: In immediate mode, `rs2_data` and `rs2_w` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| rs1_data | input | 64 | First source word |
| rs1_w | input | 2 | First source width code |
| rs2_data | input | 64 | Second source word |
| rs2_w | input | 2 | Second source width code |
| imm | input | 12 | Immediate operand |
| use_imm | input | 1 | 1 = add immediate, 0 = add second source |
| rd_w | input | 2 | Destination width code |
| is_signed | input | 1 | 1 = sign extension, 0 = zero extension |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 128 | Packed lane results |

## Verification
The properties check the handshake on every cycle: acceptance leads to a valid result, a stalled result holds, a drained register empties, reset clears, and the upper half stays zero for destinations up to 64 bits. Only the bench scenarios can show the lane arithmetic itself. These cover wrap without cross-lane carry, extension before the add, lane counts set by mixed widths, immediate truncation and replication, the 128-bit lane, and the insensitivity to the second source in immediate mode. A bench reference model written from the requirements checks these on both directed corner cases and random mixes of width codes and stalls.

// File: rtl/vla_pkg.sv
package vla_pkg;
  typedef logic [1:0] wcode_t;

  localparam wcode_t WC_BYTE   = 2'd0;
  localparam wcode_t WC_HALF   = 2'd1;
  localparam wcode_t WC_NATIVE = 2'd2;
  localparam wcode_t WC_DOUBLE = 2'd3;

  // Lane width in bits selected by a width code for a given native width.
  function automatic int unsigned code_bits(input int unsigned code, input int unsigned xlen);
    case (code)
      0:       return 8;
      1:       return xlen / 2;
      2:       return xlen;
      default: return 2 * xlen;
    endcase
  endfunction
endpackage

// File: rtl/vla_ctrl.sv
module vla_ctrl
  import vla_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LW   = $clog2(XLEN) + 1
) (
  input  wcode_t          rs1_w,
  input  wcode_t          rs2_w,
  input  wcode_t          rd_w,
  input  logic            use_imm,
  output logic [LW-1:0]   slog1,
  output logic [LW-1:0]   slog2,
  output logic [LW-1:0]   lane_log2
);
  localparam int XL = $clog2(XLEN);

  // log2 of a width code, capped at the native width
  function automatic logic [LW-1:0] capped_log2(input wcode_t c);
    case (c)
      WC_BYTE: return LW'(3);
      WC_HALF: return LW'(XL - 1);
      default: return LW'(XL);
    endcase
  endfunction

  logic [LW-1:0] dlog;

  always_comb begin
    slog1     = capped_log2(rs1_w);
    slog2     = capped_log2(rs2_w);
    dlog      = capped_log2(rd_w);
    lane_log2 = dlog;
    if (slog1 > lane_log2) lane_log2 = slog1;
    if (!use_imm && (slog2 > lane_log2)) lane_log2 = slog2;
  end
endmodule

// File: rtl/vla_group.sv
module vla_group #(
  parameter int XLEN  = 64,
  parameter int DW    = 8,
  parameter int LW    = $clog2(XLEN) + 1,
  parameter int LANES = (DW > XLEN) ? 1 : XLEN / DW
) (
  input  logic [XLEN-1:0]     rs1_data,
  input  logic [XLEN-1:0]     rs2_data,
  input  logic [XLEN-1:0]     imm_x,
  input  logic [LW-1:0]       slog1,
  input  logic [LW-1:0]       slog2,
  input  logic [LW-1:0]       lane_log2,
  input  logic                use_imm,
  input  logic                is_signed,
  output logic [LANES*DW-1:0] lanes_o
);
  localparam int WW = 2 * XLEN;

  // Element idx of a packed word at width 2^slog, extended to the lane width.
  function automatic logic [DW-1:0] pick(input logic [XLEN-1:0] w, input int unsigned idx,
                                         input logic [LW-1:0] slog, input logic sgn);
    logic [WW-1:0] raw, msk;
    int unsigned   sw;
    sw  = 32'd1 << slog;
    raw = {{XLEN{1'b0}}, w} >> (idx * sw);
    msk = (WW'(1) << sw) - WW'(1);
    raw = raw & msk;
    if (sgn && (|(raw & (msk ^ (msk >> 1))))) raw = raw | ~msk;
    return raw[DW-1:0];
  endfunction

  logic [DW-1:0] imm_el;
  always_comb imm_el = pick(imm_x, 0, slog1, is_signed);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DW-1:0] opa, opb;
    always_comb begin
      opa = pick(rs1_data, i, slog1, is_signed);
      opb = use_imm ? imm_el : pick(rs2_data, i, slog2, is_signed);
    end
    assign lanes_o[i*DW +: DW] = (((i + 1) << lane_log2) <= XLEN) ? (opa + opb) : '0;
  end
endmodule

// File: rtl/vla_outreg.sv
module vla_outreg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= '0;
      out_valid <= 1'b0;
    end else if (in_valid && in_ready) begin
      q         <= d;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vlane_adder.sv
module vlane_adder
  import vla_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   rs1_data,
  input  logic [1:0]        rs1_w,
  input  logic [XLEN-1:0]   rs2_data,
  input  logic [1:0]        rs2_w,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic [1:0]        rd_w,
  input  logic              is_signed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*XLEN-1:0] result
);
  localparam int LW = $clog2(XLEN) + 1;
  localparam int RW = 2 * XLEN;

  logic [XLEN-1:0] imm_x;
  logic [LW-1:0]   slog1, slog2, lane_log2;
  logic [RW-1:0]   grp_res [4];
  logic [RW-1:0]   res_next;

  assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  vla_ctrl #(.XLEN(XLEN), .LW(LW)) u_ctrl (
    .rs1_w     (rs1_w),
    .rs2_w     (rs2_w),
    .rd_w      (rd_w),
    .use_imm   (use_imm),
    .slog1     (slog1),
    .slog2     (slog2),
    .lane_log2 (lane_log2)
  );

  for (genvar g = 0; g < 4; g++) begin : g_width
    localparam int DW    = code_bits(g, XLEN);
    localparam int LANES = (DW > XLEN) ? 1 : XLEN / DW;
    logic [LANES*DW-1:0] lanes;
    vla_group #(.XLEN(XLEN), .DW(DW), .LW(LW), .LANES(LANES)) u_grp (
      .rs1_data  (rs1_data),
      .rs2_data  (rs2_data),
      .imm_x     (imm_x),
      .slog1     (slog1),
      .slog2     (slog2),
      .lane_log2 (lane_log2),
      .use_imm   (use_imm),
      .is_signed (is_signed),
      .lanes_o   (lanes)
    );
    assign grp_res[g] = RW'(lanes);
  end

  assign res_next = grp_res[rd_w];

  vla_outreg #(.W(RW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (res_next),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (result)
  );
endmodule

// File: rtl/vla_checker.sv
module vla_checker #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        rd_w,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2*XLEN-1:0] result
);
  logic [1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 2'd0;
    else if (in_valid && in_ready) rd_q <= rd_w;
  end

  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result));

  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && (rd_q != 2'd3) |-> result[2*XLEN-1:XLEN] == '0);

  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && (result == '0));
endmodule

bind vlane_adder vla_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_vlane_adder.sv
`timescale 1ns/1ps
module tb_vlane_adder;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready;
  logic [63:0]  rs1_data, rs2_data;
  logic [1:0]   rs1_w, rs2_w, rd_w;
  logic [11:0]  imm;
  logic         use_imm, is_signed;
  logic         out_valid, out_ready;
  logic [127:0] result;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  vlane_adder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .rs1_data(rs1_data), .rs1_w(rs1_w), .rs2_data(rs2_data), .rs2_w(rs2_w),
    .imm(imm), .use_imm(use_imm), .rd_w(rd_w), .is_signed(is_signed),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 32;
      2'd2: return 64;
      default: return 128;
    endcase
  endfunction

  function automatic logic [127:0] elem(input logic [63:0] w, input int width, input int i,
                                        input logic sgn);
    logic [127:0] v = '0;
    for (int k = 0; k < width; k++) v[k] = w[i*width + k];
    if (sgn && v[width-1]) for (int k = width; k < 128; k++) v[k] = 1'b1;
    return v;
  endfunction

  function automatic logic [127:0] model(input logic [63:0] a, input logic [63:0] b,
      input logic [1:0] w1, input logic [1:0] w2, input logic [1:0] wd,
      input logic [11:0] im, input logic ui, input logic sgn);
    logic [127:0] r = '0;
    logic [127:0] x, y, s;
    logic [63:0]  imx;
    int dw = wbits(wd);
    int e1 = (wbits(w1) > 64) ? 64 : wbits(w1);
    int e2 = (wbits(w2) > 64) ? 64 : wbits(w2);
    int m  = (dw > 64) ? 64 : dw;
    if (e1 > m) m = e1;
    if (!ui && e2 > m) m = e2;
    imx = {{52{im[11]}}, im};
    for (int i = 0; i < 64 / m; i++) begin
      x = elem(a, e1, i, sgn);
      y = ui ? elem(imx, e1, 0, sgn) : elem(b, e2, i, sgn);
      s = x + y;
      for (int k = 0; k < dw; k++) if (i*dw + k < 128) r[i*dw + k] = s[k];
    end
    return r;
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] w1,
      input logic [1:0] w2, input logic [1:0] wd, input logic [11:0] im, input logic ui,
      input logic sgn, input logic [127:0] exp, input string tag, input int stall);
    @(negedge clk);
    rs1_data = a; rs2_data = b; rs1_w = w1; rs2_w = w2; rd_w = wd;
    imm = im; use_imm = ui; is_signed = sgn; in_valid = 1'b1; out_ready = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    out_ready = (stall == 0);
    @(negedge clk);
    check(out_valid === 1'b1, {tag, " R8 valid after accept"}, {127'd0, out_valid}, 128'd1);
    check(result === exp, tag, result, exp);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(out_valid && !in_ready && result === exp, {tag, " R8 stall hold"}, result, exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    logic [1:0]  c1, c2, cd;
    logic [11:0] ri;
    logic        ru, rs;
    void'($urandom(32'd20250611));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    rs1_data = '0; rs2_data = '0; rs1_w = '0; rs2_w = '0; rd_w = '0;
    imm = '0; use_imm = 1'b0; is_signed = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9 reset valid", {127'd0, out_valid}, 128'd0);
    check(result === 128'd0, "R9 reset result", result, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R8 ready when empty", {127'd0, in_ready}, 128'd1);

    // R1 R2: byte lanes, wrap without carry into neighbours
    run_op(64'h01FF_7F80_0000_00FF, 64'h0101_0180_0000_0001, 2'd0, 2'd0, 2'd0, 12'h0, 1'b0,
           1'b0, 128'h0000_0000_0000_0000_0200_8000_0000_0000, "R1 R2 byte wrap", 0);
    // R4 R3: 8-bit sources into 32-bit lanes, unsigned then signed
    run_op(64'h0000_0000_0000_80FF, 64'h0000_0000_0000_0001, 2'd0, 2'd0, 2'd1, 12'h0, 1'b0,
           1'b0, 128'h0000_0000_0000_0080_0000_0100, "R4 widen unsigned", 0);
    run_op(64'h0000_0000_0000_80FF, 64'h0000_0000_0000_0001, 2'd0, 2'd0, 2'd1, 12'h0, 1'b0,
           1'b1, 128'h0000_0000_0000_0000_FFFF_FF80_0000_0000, "R3 widen signed", 2);
    // R5: 32-bit first source with 8-bit destination gives two truncated lanes
    run_op(64'hAAAA_AA10_BBBB_BB20, 64'h0000_0000_0000_0302, 2'd1, 2'd0, 2'd0, 12'h0, 1'b0,
           1'b0, 128'h1322, "R5 lane count", 1);
    // R6: immediate replicated across byte lanes
    run_op(64'h0102_0304_0506_0708, 64'hDEAD_BEEF_0000_1111, 2'd0, 2'd0, 2'd0, 12'h123, 1'b1,
           1'b0, 128'h2425_2627_2829_2A2B, "R6 imm replicate", 0);
    // R6: immediate cut to 32 bits then zero/sign extended into a 64-bit lane
    run_op(64'h1234_5678_0000_0001, 64'h0, 2'd1, 2'd0, 2'd2, 12'hFFF, 1'b1, 1'b0,
           128'h0000_0001_0000_0000, "R6 imm zero ext", 0);
    run_op(64'h1234_5678_0000_0001, 64'h0, 2'd1, 2'd0, 2'd2, 12'hFFF, 1'b1, 1'b1,
           128'h0, "R6 imm sign ext", 0);
    // R10: same immediate op with a different second source and width
    run_op(64'h0102_0304_0506_0708, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd1, 2'd0, 12'h123, 1'b1,
           1'b0, 128'h2425_2627_2829_2A2B, "R10 rs2 ignored", 0);
    // R7: single 128-bit lane
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 2'd2, 2'd3, 12'h0, 1'b0,
           1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFE, "R7 double signed", 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 2'd2, 2'd3, 12'h0, 1'b0,
           1'b0, 128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFE, "R7 double unsigned", 0);

    // Random mix against the reference model (R1-style packing, R2..R7, R10)
    for (int n = 0; n < 400; n++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      c1 = 2'($urandom); c2 = 2'($urandom); cd = 2'($urandom);
      ri = 12'($urandom); ru = 1'($urandom); rs = 1'($urandom);
      run_op(ra, rb, c1, c2, cd, ri, ru, rs, model(ra, rb, c1, c2, cd, ri, ru, rs),
             "R5 R6 random vs model", int'($urandom % 3));
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule